// File: doc/BRIEF.md
# Memory Retention Pattern Test Engine

A built-in test sequencer that hunts for retention and data-dependent cell failures in a memory region reached through a simple synchronous port. Once started, it runs a configured number of rounds. In each round it writes every word of the region with one data pattern. It then idles for a programmable number of cycles, so that weak cells have time to leak, and reads the whole region back. Each word read is compared with the value that was written.

The patterns rotate round by round through five kinds: all zeros, all ones, 0x55-style alternation, 0xAA-style alternation and pseudo-random words. Many rounds are needed, because a weak cell often fails only when its neighbours hold particular values. Running the same region under several fills exposes such cells. Random words come from an LFSR that is reseeded from the round number. Readback reseeds it with the same seed, so no copy of the written data is kept. Every mismatch produces a one-cycle report carrying the address, pattern code and round, and it bumps a saturating failure counter.

Top module: `rtest_engine`

## Requirements
- R1: After reset the engine is idle: `done_o`, `fail_valid_o`, `mem_we_o` and `mem_re_o` are 0 and `fail_cnt_o` is 0.
- R2: `start_i` is accepted only while idle or done; acceptance latches `cfg_rounds_i` and `cfg_wait_i`. A `start_i` during a run is ignored and leaves the round count and timing unchanged.
- R3: Each round writes addresses 0 to 2^ADDR_W-1 in ascending order, one per cycle, with `mem_we_o` high. The pattern code is the round number modulo 5: 0 all zeros, 1 all ones, 2 bit i = ~i[0] (0x55), 3 bit i = i[0] (0xAA), 4 random.
- R4: Random words come from a shift-left LFSR whose new bit 0 is the XOR of the state bits selected by TAPS (0xB8 for 8 bits). The seed is (SEED ^ round) | 1. The word at address a is the state after a steps from the seed.
- R5: The wait phase lasts cfg_wait+1 cycles, so one round takes 2·2^ADDR_W + cfg_wait + RD_LAT + 2 cycles. `done_o` rises rounds × that many cycles after the edge that accepts start. With zero rounds it rises on that same edge.
- R6: Readback issues addresses 0 to 2^ADDR_W-1 in ascending order, one per cycle, with `mem_re_o` high. Read data is expected RD_LAT cycles after its issue.
- R7: Each mismatching word gives one cycle of `fail_valid_o`, RD_LAT+1 cycles after that word's read issue. The report carries its address, the pattern code and the round number, and reports come in read order.
- R8: `fail_cnt_o` counts reports, saturates at 2^CNT_W-1 and is cleared when a start is accepted.
- R9: `done_o` stays high until the next accepted start. Words that read back correctly produce no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| cfg_rounds_i | input | RND_W | Number of rounds |
| cfg_wait_i | input | WAIT_W | Retention pause length in cycles (minus one) |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read issue |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, RD_LAT cycles after issue |
| fail_valid_o | output | 1 | Failure report strobe |
| fail_addr_o | output | ADDR_W | Failing address |
| fail_pat_o | output | 3 | Pattern code of the failing round |
| fail_round_o | output | RND_W | Failing round number |
| fail_cnt_o | output | CNT_W | Saturating failure count |
| done_o | output | 1 | Test finished |

## Verification
Write and read strobes are combinational from state, so each one is sampled in the cycle that it addresses. Failure reports are due exactly RD_LAT+1 cycles after the matching read issue. The bench keeps a short ring of past read issues and checks every report against the entry that many cycles back. `done_o` is due a fixed number of cycles after the accepting edge, as given by R5. The bench counts falling edges from that edge and compares the count with the arithmetic value. The bench memory model drops charge from two weak cells. One of them fails only under a particular neighbouring bit value and only after long pauses, so the expected report list comes from the pattern formulas alone.

// File: rtl/rtest_pkg.sv
package rtest_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_WAIT, ST_READ, ST_NEXT, ST_DONE
  } state_e;

  localparam int unsigned NUM_PAT = 5;
  localparam int unsigned PAT_W   = 3;

  localparam logic [PAT_W-1:0] PAT_ZERO  = 3'd0;
  localparam logic [PAT_W-1:0] PAT_ONE   = 3'd1;
  localparam logic [PAT_W-1:0] PAT_ALT01 = 3'd2;
  localparam logic [PAT_W-1:0] PAT_ALT10 = 3'd3;
  localparam logic [PAT_W-1:0] PAT_RAND  = 3'd4;
endpackage

// File: rtl/rtest_lfsr.sv
module rtest_lfsr #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= W'(1);
    else if (load_i) state_q <= seed_i;
    else if (step_i) state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign state_o = state_q;
endmodule

// File: rtl/rtest_rd_pipe.sv
module rtest_rd_pipe #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_v_i,
  input  logic [W-1:0]     in_d_i,
  output logic [DEPTH-1:0] v_o,
  output logic [W-1:0]     out_d_o
);
  logic [DEPTH-1:0] v_q;
  logic [W-1:0]     d_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[0] <= 1'b0;
          d_q[0] <= '0;
        end else begin
          v_q[0] <= in_v_i;
          d_q[0] <= in_d_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[g] <= 1'b0;
          d_q[g] <= '0;
        end else begin
          v_q[g] <= v_q[g-1];
          d_q[g] <= d_q[g-1];
        end
      end
    end
  end

  assign v_o     = v_q;
  assign out_d_o = d_q[DEPTH-1];
endmodule

// File: rtl/rtest_engine.sv
module rtest_engine
  import rtest_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RD_LAT = 2,
  parameter int unsigned RND_W  = 16,
  parameter int unsigned WAIT_W = 24,
  parameter int unsigned CNT_W  = 16,
  parameter logic [DATA_W-1:0] SEED = 32'h1234_5A5A,
  parameter logic [DATA_W-1:0] TAPS = 32'h8020_0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RND_W-1:0]  cfg_rounds_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              fail_valid_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [PAT_W-1:0]  fail_pat_o,
  output logic [RND_W-1:0]  fail_round_o,
  output logic [CNT_W-1:0]  fail_cnt_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [RD_LAT-1:0] LOW_MASK  = {RD_LAT{1'b1}} >> 1;
  localparam int unsigned       PIPE_W    = ADDR_W + DATA_W;

  state_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              iss_done_q;
  logic [WAIT_W-1:0] wait_q, cfg_wait_q;
  logic [RND_W-1:0]  round_q, cfg_rounds_q, seed_rnd;
  logic [PAT_W-1:0]  pat_q;
  logic [DATA_W-1:0] lfsr, seed, pat_word, alt01;
  logic              lfsr_load, lfsr_step, idle_start, cmp_fail;
  logic [RD_LAT-1:0] pipe_v;
  logic [PIPE_W-1:0] pipe_out;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] exp_data;

  assign idle_start = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    for (int i = 0; i < int'(DATA_W); i++) alt01[i] = ~i[0];
    unique case (pat_q)
      PAT_ZERO:  pat_word = '0;
      PAT_ONE:   pat_word = '1;
      PAT_ALT01: pat_word = alt01;
      PAT_ALT10: pat_word = ~alt01;
      default:   pat_word = lfsr;
    endcase
  end

  // Seed selection: round 0 on start, same round on readback, next round after NEXT
  always_comb begin
    lfsr_load = 1'b0;
    lfsr_step = 1'b0;
    seed_rnd  = round_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        lfsr_load = start_i;
        seed_rnd  = '0;
      end
      ST_WRITE: lfsr_step = 1'b1;
      ST_WAIT:  lfsr_load = (wait_q == cfg_wait_q);
      ST_READ:  lfsr_step = !iss_done_q;
      ST_NEXT: begin
        lfsr_load = 1'b1;
        seed_rnd  = round_q + 1'b1;
      end
      default: ;
    endcase
  end

  assign seed = (SEED ^ DATA_W'(seed_rnd)) | DATA_W'(1);

  rtest_lfsr #(.W(DATA_W), .TAPS(TAPS)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (lfsr_load),
    .step_i (lfsr_step),
    .seed_i (seed),
    .state_o(lfsr)
  );

  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_re_o    = (state_q == ST_READ) && !iss_done_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = pat_word;

  rtest_rd_pipe #(.DEPTH(RD_LAT), .W(PIPE_W)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_v_i (mem_re_o),
    .in_d_i ({addr_q, pat_word}),
    .v_o    (pipe_v),
    .out_d_o(pipe_out)
  );

  assign {exp_addr, exp_data} = pipe_out;
  assign cmp_fail = pipe_v[RD_LAT-1] && (mem_rdata_i != exp_data);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      iss_done_q   <= 1'b0;
      wait_q       <= '0;
      cfg_wait_q   <= '0;
      cfg_rounds_q <= '0;
      round_q      <= '0;
      pat_q        <= PAT_ZERO;
      fail_cnt_o   <= '0;
    end else begin
      if (cmp_fail && fail_cnt_o != CNT_MAX) fail_cnt_o <= fail_cnt_o + 1'b1;
      unique case (state_q)
        ST_IDLE, ST_DONE: if (idle_start) begin
          cfg_rounds_q <= cfg_rounds_i;
          cfg_wait_q   <= cfg_wait_i;
          round_q      <= '0;
          pat_q        <= PAT_ZERO;
          addr_q       <= '0;
          fail_cnt_o   <= '0;
          state_q      <= (cfg_rounds_i == '0) ? ST_DONE : ST_WRITE;
        end
        ST_WRITE: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == LAST_ADDR) begin
            wait_q  <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          wait_q <= wait_q + 1'b1;
          if (wait_q == cfg_wait_q) begin
            addr_q     <= '0;
            iss_done_q <= 1'b0;
            state_q    <= ST_READ;
          end
        end
        ST_READ: begin
          if (!iss_done_q) begin
            addr_q <= addr_q + 1'b1;
            if (addr_q == LAST_ADDR) iss_done_q <= 1'b1;
          end else if ((pipe_v & LOW_MASK) == '0) begin
            state_q <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          round_q <= round_q + 1'b1;
          pat_q   <= (pat_q == PAT_W'(NUM_PAT - 1)) ? PAT_ZERO : pat_q + 1'b1;
          addr_q  <= '0;
          state_q <= ({1'b0, round_q} + 1'b1 == {1'b0, cfg_rounds_q}) ? ST_DONE : ST_WRITE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_valid_o <= 1'b0;
      fail_addr_o  <= '0;
      fail_pat_o   <= '0;
      fail_round_o <= '0;
    end else begin
      fail_valid_o <= cmp_fail;
      if (cmp_fail) begin
        fail_addr_o  <= exp_addr;
        fail_pat_o   <= pat_q;
        fail_round_o <= round_q;
      end
    end
  end

  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/rtest_engine_chk.sv
module rtest_engine_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic              fail_valid_o,
  input logic [CNT_W-1:0]  fail_cnt_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_cnt_monotonic_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (fail_cnt_o >= $past(fail_cnt_o)));

  assert_cnt_saturates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_cnt_o == CNT_MAX && !start_i) |=> (fail_cnt_o == CNT_MAX));

  assert_report_counted_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_valid_o |-> (fail_cnt_o != '0));

  assert_no_report_when_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_valid_o |-> !done_o);

  assert_done_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_write_ascending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (!mem_we_o || mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));
endmodule

bind rtest_engine rtest_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .done_o      (done_o),
  .fail_valid_o(fail_valid_o),
  .fail_cnt_o  (fail_cnt_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/rtest_engine_tb.sv
module rtest_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 16;
  localparam int RD_LAT     = 2;
  localparam int CMAX       = 15;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] cfg_rounds_i = '0;
  logic [7:0] cfg_wait_i = '0;
  logic [3:0] mem_addr_o;
  logic       mem_we_o, mem_re_o;
  logic [7:0] mem_wdata_o, mem_rdata_i;
  logic       fail_valid_o;
  logic [3:0] fail_addr_o;
  logic [2:0] fail_pat_o;
  logic [7:0] fail_round_o;
  logic [3:0] fail_cnt_o;
  logic       done_o;

  int checks = 0, errors = 0, cur_wait = 0, cyc = 0, rep_n = 0, wr_idx = 0, rd_idx = 0;
  bit finished = 0;
  int q_r[$], q_a[$], q_p[$];
  bit hist_re[8];
  int hist_a[8];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtest_engine #(.ADDR_W(4), .DATA_W(8), .RD_LAT(RD_LAT), .RND_W(8), .WAIT_W(8),
                 .CNT_W(4), .SEED(8'h5A), .TAPS(8'hB8)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cfg_rounds_i(cfg_rounds_i),
    .cfg_wait_i(cfg_wait_i), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .fail_valid_o(fail_valid_o), .fail_addr_o(fail_addr_o), .fail_pat_o(fail_pat_o),
    .fail_round_o(fail_round_o), .fail_cnt_o(fail_cnt_o), .done_o(done_o));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(int pat, int rnd, int a);
    logic [7:0] s;
    case (pat)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h55;
      3: return 8'hAA;
      default: begin
        s = (8'h5A ^ 8'(rnd)) | 8'h01;
        for (int k = 0; k < a; k++) s = {s[6:0], ^(s & 8'hB8)};
        return s;
      end
    endcase
  endfunction

  // Weak cells: addr 5 bit0 leaks when bit1 is 0; addr 10 bit7 leaks; both need a long pause
  function automatic logic [7:0] decay(int a, logic [7:0] w);
    logic [7:0] r = w;
    if (cur_wait >= 20) begin
      if (a == 5 && w[0] && !w[1]) r[0] = 1'b0;
      if (a == 10 && w[7]) r[7] = 1'b0;
    end
    return r;
  endfunction

  logic [7:0] mem [N];
  logic [7:0] rd_q [RD_LAT];
  initial for (int i = 0; i < N; i++) mem[i] = '0;
  always @(posedge clk_i) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    rd_q[0] <= decay(int'(mem_addr_o), mem[mem_addr_o]);
    for (int i = 1; i < RD_LAT; i++) rd_q[i] <= rd_q[i-1];
  end
  assign mem_rdata_i = rd_q[RD_LAT-1];

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (fail_valid_o) begin
        rep_n++;
        chk(cyc >= RD_LAT + 1 && hist_re[(cyc - RD_LAT - 1) & 7] &&
            hist_a[(cyc - RD_LAT - 1) & 7] == int'(fail_addr_o),
            "R7", "report timing vs read issue", fail_addr_o, hist_a[(cyc - RD_LAT - 1) & 7]);
        if (q_a.size() == 0) chk(0, "R9", "unexpected report addr", fail_addr_o, -1);
        else begin
          chk(int'(fail_addr_o) == q_a[0], "R7", "report addr", fail_addr_o, q_a[0]);
          chk(int'(fail_round_o) == q_r[0], "R7", "report round", fail_round_o, q_r[0]);
          chk(int'(fail_pat_o) == q_p[0], "R3", "report pattern code", fail_pat_o, q_p[0]);
          void'(q_a.pop_front()); void'(q_r.pop_front()); void'(q_p.pop_front());
        end
      end
      if (mem_we_o) begin
        chk(int'(mem_addr_o) == wr_idx % N, "R3", "write address", mem_addr_o, wr_idx % N);
        chk(mem_wdata_o == exp_word((wr_idx / N) % 5, wr_idx / N, wr_idx % N),
            (wr_idx / N) % 5 == 4 ? "R4" : "R3", "write data", mem_wdata_o,
            exp_word((wr_idx / N) % 5, wr_idx / N, wr_idx % N));
        wr_idx++;
      end
      if (mem_re_o) begin
        chk(int'(mem_addr_o) == rd_idx % N, "R6", "read address", mem_addr_o, rd_idx % N);
        rd_idx++;
      end
      hist_re[cyc & 7] = mem_re_o;
      hist_a[cyc & 7]  = int'(mem_addr_o);
    end
    cyc++;
  end

  task automatic run(int rounds, int wt, bit poke);
    int total = 0, n = 0, expc;
    logic [7:0] w;
    cur_wait = wt;
    for (int r = 0; r < rounds; r++)
      for (int a = 0; a < N; a++) begin
        w = exp_word(r % 5, r, a);
        if (decay(a, w) != w) begin
          q_r.push_back(r); q_a.push_back(a); q_p.push_back(r % 5);
          total++;
        end
      end
    rep_n = 0; wr_idx = 0; rd_idx = 0;
    @(negedge clk_i);
    start_i = 1'b1; cfg_rounds_i = 8'(rounds); cfg_wait_i = 8'(wt);
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && n < 20000) begin
      if (poke && n == 10) begin start_i = 1'b1; cfg_rounds_i = 8'd1; cfg_wait_i = 8'd0; end
      if (poke && n == 11) start_i = 1'b0;
      @(negedge clk_i);
      n++;
    end
    expc = rounds * (2 * N + wt + RD_LAT + 2);
    chk(n == expc, poke ? "R2" : "R5", "cycles to done", n, expc);
    for (int k = 0; k < 4; k++) @(negedge clk_i);
    chk(done_o == 1'b1, "R9", "done held", done_o, 1);
    chk(rep_n == total, "R7", "report count", rep_n, total);
    chk(q_a.size() == 0, "R7", "missing reports", q_a.size(), 0);
    chk(int'(fail_cnt_o) == (total > CMAX ? CMAX : total), "R8", "fail count",
        fail_cnt_o, total > CMAX ? CMAX : total);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      chk(0, "ALL", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!done_o && !fail_valid_o && !mem_we_o && !mem_re_o && fail_cnt_o == 0,
        "R1", "reset state", {done_o, fail_valid_o, mem_we_o, mem_re_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!done_o && !mem_we_o && !mem_re_o && fail_cnt_o == 0, "R1", "idle after reset",
        {done_o, mem_we_o, mem_re_o}, 0);
    run(5, 30, 0);   // R3 R7: failures under ones, 0x55, 0xAA
    run(3, 5, 1);    // R2 R9: short pause, no failures, busy start ignored
    run(0, 7, 0);    // R5 R8: zero rounds, count cleared
    run(40, 25, 0);  // R4 R8: many random rounds, counter saturates
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule